// File: doc/BRIEF.md
# Ethernet Pause and Backpressure Timer

This block paces flow control on the transmit side of an Ethernet MAC. The receive-buffer logic raises `fc_request` when it wants the link partner to stop sending, and lowers it when it has room again. The block reads the duplex mode and a 32-bit setting word. The low half of the word is the repeat interval. The high half is the pause value.

In full duplex, a rising request makes the block ask the frame generator for a pause control frame. The request carries the pause value as its pause time. The block then repeats the request each time its cycle counter reaches the repeat interval. When the request drops, the block asks for one last frame with a pause time of zero, so the partner can resume at once. Requests to the frame generator are single-cycle pulses. A request that arises while an earlier one is still unacknowledged is held back and issued once the acknowledge arrives.

In half duplex, the block raises a backpressure line for a number of cycles equal to the pause value, and sends no frames. The same counter serves both modes, and its live value is visible on a read-only status word.

Top module: `eth_flow_pacer`

## Requirements
- R1: After reset, `pause_req`, `backpressure`, `pause_time` and `fc_status` are all zero.
- R2: In full duplex, when `fc_request` rises and no frame request is outstanding, `pause_req` pulses in the cycle after the rising edge is sampled, and `pause_time` equals `flow_cfg[31:16]`.
- R3: In full duplex with a non-zero interval I = `flow_cfg[15:0]`, `fc_status[15:0]` counts 0,1,…,I starting the cycle after the request is sampled, then wraps to 0. A new frame request is made every I+1 cycles for as long as the request stays high.
- R4: `pause_req` is high for one cycle per request. While a request is unacknowledged (no `pause_done` since the last pulse), no new pulse appears. A held request is issued in the cycle after `pause_done` is sampled, carrying the most recent pause time.
- R5: In full duplex, when `fc_request` falls, a frame request with `pause_time` = 0 is made. No further repeats follow.
- R6: In half duplex, `backpressure` is high for exactly `flow_cfg[31:16]` cycles, starting the cycle after the request is sampled. No frame request is made in half duplex.
- R7: In half duplex, `fc_status[15:0]` counts from 0 up to the pause value and then holds there while the request stays high.
- R8: `fc_status[31:16]` always reads zero. `fc_status` returns to zero the cycle after `fc_request` is sampled low.
- R9: In full duplex with an interval of zero, exactly one frame request is made when the request rises, with no repeats, and the status stays at zero.
- R10: In half duplex with a pause value of zero, `backpressure` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| full_duplex | input | 1 | 1 = full duplex (pause frames), 0 = half duplex (backpressure) |
| flow_cfg | input | 32 | [15:0] repeat interval, [31:16] pause value |
| fc_request | input | 1 | Level request for flow control from the receive-buffer logic |
| pause_done | input | 1 | One-cycle acknowledge from the frame generator for the last request |
| pause_req | output | 1 | One-cycle request to send a pause frame |
| pause_time | output | 16 | Pause time for the frame, valid with `pause_req` and held afterwards |
| backpressure | output | 1 | Half-duplex backpressure (carrier assertion) request |
| fc_status | output | 32 | Live counter in [15:0], zero in [31:16] |

## Verification
The assertions assume that `full_duplex` and `flow_cfg` are held steady while `fc_request` is high. They also assume that `pause_done` comes only while a request is outstanding. The stimulus changes mode and settings only while the request is low. A bench model of the frame generator acknowledges each pulse once, after a set delay. Two delays are used: one shorter than the repeat period, which gives plain repetition, and one longer, which forces the held-request path.

// File: rtl/fcp_pkg.sv
package fcp_pkg;
  // Request phase derived from the current and previous request level
  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_STOP  = 2'b01,
    PH_START = 2'b10,
    PH_RUN   = 2'b11
  } fc_phase_e;
endpackage

// File: rtl/fcp_rst_sync.sv
module fcp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/fcp_phase_tracker.sv
module fcp_phase_tracker
  import fcp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fc_request,
  output fc_phase_e phase
);
  logic req_d_q;
  logic req_d_n;
  logic req_d_en;

  always_comb begin
    req_d_n  = fc_request;
    req_d_en = (req_d_n != req_d_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        req_d_q <= 1'b0;
    else if (req_d_en) req_d_q <= req_d_n;
  end

  assign phase = fc_phase_e'({fc_request, req_d_q});
endmodule

// File: rtl/fcp_interval_counter.sv
module fcp_interval_counter
  import fcp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fc_phase_e        phase,
  input  logic             full_duplex,
  input  logic [CNT_W-1:0] interval,
  input  logic [CNT_W-1:0] pause_val,
  output logic [CNT_W-1:0] cnt,
  output logic             bp,
  output logic             repeat_trig
);
  logic [CNT_W-1:0] cnt_q, cnt_n, cnt_inc;
  logic             bp_q, bp_n;
  logic             cnt_en, bp_en;

  assign cnt_inc = cnt_q + CNT_W'(1);

  always_comb begin
    cnt_n       = '0;
    bp_n        = 1'b0;
    repeat_trig = 1'b0;
    unique case (phase)
      PH_START: begin
        cnt_n = '0;
        bp_n  = !full_duplex && (pause_val != '0);
      end
      PH_RUN: begin
        if (full_duplex) begin
          if (interval == '0) begin
            cnt_n = '0;
          end else if (cnt_q == interval) begin
            cnt_n       = '0;
            repeat_trig = 1'b1;
          end else begin
            cnt_n = cnt_inc;
          end
        end else if (bp_q) begin
          cnt_n = cnt_inc;
          bp_n  = (cnt_inc != pause_val);
        end else begin
          cnt_n = cnt_q;
        end
      end
      default: begin
        cnt_n = '0;
        bp_n  = 1'b0;
      end
    endcase
    cnt_en = (cnt_n != cnt_q);
    bp_en  = (bp_n != bp_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      bp_q  <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_n;
      if (bp_en)  bp_q  <= bp_n;
    end
  end

  assign cnt = cnt_q;
  assign bp  = bp_q;

  // R3
  fd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUN && full_duplex && interval != '0) |-> (cnt_q <= interval));

  // R7
  hd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUN && !full_duplex) |-> (cnt_q <= pause_val));

  // R10
  hd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_START && !full_duplex && pause_val == '0) |=> !bp_q);
endmodule

// File: rtl/fcp_pause_issuer.sv
module fcp_pause_issuer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [CNT_W-1:0] trig_time,
  input  logic             pause_done,
  output logic             pause_req,
  output logic [CNT_W-1:0] pause_time
);
  logic             req_q, req_n;
  logic [CNT_W-1:0] time_q, time_n;
  logic             outst_q, outst_n;
  logic             pend_q, pend_n;
  logic [CNT_W-1:0] ptime_q, ptime_n;
  logic             can_issue, have_work;
  logic [CNT_W-1:0] src_time;
  logic             time_en, ptime_en;

  always_comb begin
    can_issue = !outst_q || pause_done;
    have_work = trig || pend_q;
    src_time  = trig ? trig_time : ptime_q;
    req_n     = 1'b0;
    time_n    = time_q;
    outst_n   = outst_q;
    pend_n    = pend_q;
    ptime_n   = ptime_q;
    if (pause_done) outst_n = 1'b0;
    if (have_work && can_issue) begin
      req_n   = 1'b1;
      time_n  = src_time;
      outst_n = 1'b1;
      pend_n  = 1'b0;
    end else if (trig) begin
      pend_n  = 1'b1;
      ptime_n = trig_time;
    end
    time_en  = (time_n != time_q);
    ptime_en = (ptime_n != ptime_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      time_q  <= '0;
      outst_q <= 1'b0;
      pend_q  <= 1'b0;
      ptime_q <= '0;
    end else begin
      req_q   <= req_n;
      outst_q <= outst_n;
      pend_q  <= pend_n;
      if (time_en)  time_q  <= time_n;
      if (ptime_en) ptime_q <= ptime_n;
    end
  end

  assign pause_req  = req_q;
  assign pause_time = time_q;

  // R4
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outst_q && !pause_done) |=> !req_q);

  // R2
  issue_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && can_issue) |=> (req_q && time_q == $past(trig_time)));

  // R4
  held_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && pause_done) |=> req_q);
endmodule

// File: rtl/eth_flow_pacer.sv
module eth_flow_pacer
  import fcp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               full_duplex,
  input  logic [2*CNT_W-1:0] flow_cfg,
  input  logic               fc_request,
  input  logic               pause_done,
  output logic               pause_req,
  output logic [CNT_W-1:0]   pause_time,
  output logic               backpressure,
  output logic [2*CNT_W-1:0] fc_status
);
  localparam int CFG_W = 2 * CNT_W;

  logic             rst_sync_n;
  fc_phase_e        phase;
  logic [CNT_W-1:0] interval, pause_val, cnt;
  logic             repeat_trig, trig;
  logic [CNT_W-1:0] trig_time;

  assign interval  = flow_cfg[CNT_W-1:0];
  assign pause_val = flow_cfg[CFG_W-1:CNT_W];

  fcp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fcp_phase_tracker u_phase (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .fc_request (fc_request),
    .phase      (phase)
  );

  fcp_interval_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .phase       (phase),
    .full_duplex (full_duplex),
    .interval    (interval),
    .pause_val   (pause_val),
    .cnt         (cnt),
    .bp          (backpressure),
    .repeat_trig (repeat_trig)
  );

  // Frame requests: start, periodic repeat, and the zero-time release frame
  always_comb begin
    trig      = full_duplex &&
                (phase == PH_START || phase == PH_STOP || repeat_trig);
    trig_time = (phase == PH_STOP) ? '0 : pause_val;
  end

  fcp_pause_issuer #(.CNT_W(CNT_W)) u_issue (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .trig       (trig),
    .trig_time  (trig_time),
    .pause_done (pause_done),
    .pause_req  (pause_req),
    .pause_time (pause_time)
  );

  assign fc_status = {{CNT_W{1'b0}}, cnt};

  // R6
  bp_half_only_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    backpressure |-> $past(!full_duplex));

  // R8
  idle_status_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !fc_request |=> (fc_status == '0));

  // R5
  release_frame_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase == PH_STOP && full_duplex) |=> (pause_time == '0 || !pause_req));
endmodule

// File: tb/sim_eth_flow_pacer.sv
module sim_eth_flow_pacer;
  typedef struct {
    int          cyc;
    logic [15:0] ptime;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        full_duplex = 1'b1;
  logic [31:0] flow_cfg = '0;
  logic        fc_request = 1'b0;
  logic        pause_done = 1'b0;
  logic        pause_req;
  logic [15:0] pause_time;
  logic        backpressure;
  logic [31:0] fc_status;

  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  int   ack_dly = 2;
  int   ack_cnt = 0;
  exp_t expq[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  eth_flow_pacer u0 (
    .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .flow_cfg(flow_cfg),
    .fc_request(fc_request), .pause_done(pause_done), .pause_req(pause_req),
    .pause_time(pause_time), .backpressure(backpressure), .fc_status(fc_status)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push(input int c, input logic [15:0] t, input string req);
    exp_t e;
    e.cyc = c; e.ptime = t; e.req = req;
    expq.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor and frame-generator model: pops expected requests, acks after ack_dly
  always @(negedge clk) begin
    pause_done <= 1'b0;
    if (pause_req) begin
      if (expq.size() == 0) begin
        check(1'b0, "R4 unexpected request", cyc, -1);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(e.cyc == cyc, e.req, cyc, e.cyc);
        check(pause_time == e.ptime, e.req, int'(pause_time), int'(e.ptime));
      end
      ack_cnt = ack_dly;
    end else if (ack_cnt > 0) begin
      ack_cnt--;
      if (ack_cnt == 0) pause_done <= 1'b1;
    end
  end

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : driver
    int n;
    step(3);
    rst_n = 1'b1;
    step(5);
    // R1 reset state
    check(pause_req == 0 && backpressure == 0, "R1", int'(pause_req) + int'(backpressure), 0);
    check(pause_time == 0 && fc_status == 0, "R1", int'(fc_status), 0);

    // Full duplex, fast acknowledge: start, repeats, release (R2 R3 R5)
    full_duplex = 1'b1; ack_dly = 2;
    flow_cfg = {16'h1234, 16'd9};
    step(1);
    n = cyc;
    fc_request = 1'b1;
    push(n + 1,  16'h1234, "R2 start frame");
    push(n + 11, 16'h1234, "R3 first repeat");
    push(n + 21, 16'h1234, "R3 second repeat");
    step(5);
    check(fc_status == 32'd4, "R3 status count", int'(fc_status), 4);
    step(5);
    check(fc_status == 32'd9, "R3 status at interval", int'(fc_status), 9);
    step(1);
    check(fc_status == 32'd0, "R3 status wrap", int'(fc_status), 0);
    step(14);
    fc_request = 1'b0;
    push(n + 26, 16'h0000, "R5 release frame");
    step(3);
    check(fc_status == 32'd0, "R8 status idle", int'(fc_status), 0);
    step(10);
    check(expq.size() == 0, "R3 all frames seen", expq.size(), 0);

    // Slow acknowledge forces held requests (R4)
    ack_dly = 20;
    flow_cfg = {16'h00AA, 16'd3};
    step(1);
    n = cyc;
    fc_request = 1'b1;
    push(n + 1,  16'h00AA, "R4 first frame");
    push(n + 22, 16'h00AA, "R4 held repeat");
    push(n + 43, 16'h00AA, "R4 held repeat 2");
    step(50);
    fc_request = 1'b0;
    push(n + 64, 16'h0000, "R4 held release frame");
    step(40);
    check(expq.size() == 0, "R4 all frames seen", expq.size(), 0);

    // Zero interval: single frame (R9)
    ack_dly = 2;
    flow_cfg = {16'h0007, 16'd0};
    step(1);
    n = cyc;
    fc_request = 1'b1;
    push(n + 1, 16'h0007, "R9 single frame");
    step(30);
    check(fc_status == 32'd0, "R9 status stays zero", int'(fc_status), 0);
    fc_request = 1'b0;
    push(n + 31, 16'h0000, "R9 release frame");
    step(10);
    check(expq.size() == 0, "R9 all frames seen", expq.size(), 0);

    // Half duplex backpressure (R6 R7 R8)
    full_duplex = 1'b0;
    flow_cfg = {16'd5, 16'd9};
    step(1);
    fc_request = 1'b1;
    for (int k = 1; k <= 9; k++) begin
      step(1);
      check(backpressure == (k <= 5), "R6 backpressure window", int'(backpressure), int'(k <= 5));
      check(fc_status == ((k - 1 < 5) ? k - 1 : 5), "R7 status", int'(fc_status), (k - 1 < 5) ? k - 1 : 5);
      check(fc_status[31:16] == 16'd0, "R8 upper bits", int'(fc_status[31:16]), 0);
    end
    fc_request = 1'b0;
    step(2);
    check(fc_status == 0 && backpressure == 0, "R8 half release", int'(fc_status), 0);

    // Half duplex zero pause value (R10)
    flow_cfg = {16'd0, 16'd9};
    step(1);
    fc_request = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      step(1);
      check(backpressure == 1'b0, "R10 no backpressure", int'(backpressure), 0);
    end
    fc_request = 1'b0;
    step(5);
    check(expq.size() == 0, "R6 no frames in half duplex", expq.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule